// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer that counts pulses of a slow tick input, one CPU clock wide, and raises an interrupt, a system reset request, or both when software stops restarting it in time. Software reaches it through one 8-bit control register. Each write is one cycle on the write strobe, and the read port always shows the current register contents. A strap input, which is static while out of reset, picks one of two safety levels. Level one starts disabled and lets software turn the watchdog on freely. Level two keeps it on at all times.

Two kinds of change are guarded by a two-write unlock: turning the watchdog off at level one, and changing the timeout at level two. The first write arms a short window. The second write must come within that window and carries the new settings. If the window passes unused it closes by itself, and protected writes are ignored again. The register carries no stream data, so all pins are plain control and status signals and there is no handshake.

Register layout: bits 7:4 timeout select, bit 3 enable, bit 2 change-enable, bit 1 interrupt enable, bit 0 timeout flag.

Top module: `wdt_guarded`

## Requirements
- R1: After reset at level one the register reads 0x00. At level two it reads 0x08: enable shown as one, timeout select 0.
- R2: At level one, a write with bit 3 set turns the watchdog on. A write with bit 3 clear outside a valid unlock second step leaves it on.
- R3: At level two, bit 3 always reads one, and the bit 3 value in a second unlock step has no effect.
- R4: A single write with bit 2 and bit 3 both one opens the unlock window, and bit 2 reads one while the window is open.
- R5: A write with bit 2 clear, made in any of the WIN_CYC (default 4) cycles after the arming write, is accepted. At level one it loads the enable and the timeout select; at level two it loads only the timeout select. It also closes the window.
- R6: If no write arrives within those WIN_CYC cycles, bit 2 clears by itself and a later protected write is ignored.
- R7: At level one any write loads the timeout select. At level two only an accepted second step does.
- R8: While the watchdog is running, a timeout occurs every 2^(BASE_EXP+c) ticks, where c is the timeout select limited to TOP_CODE. Codes above TOP_CODE act like TOP_CODE.
- R9: With enable one and interrupt enable zero, a timeout pulses the reset request high for exactly one cycle, and counting starts again from zero.
- R10: The restart input clears the tick count, so the next timeout falls a full period after the restart.
- R11: With interrupt enable one, a timeout sets the flag when the flag is clear. The interrupt output equals flag AND interrupt enable. A timeout that finds the flag already set requests reset if enable is one, and does nothing if enable is zero.
- R12: Writing one to bit 0 clears the flag. Writing zero to bit 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_lvl2 | input | 1 | Safety level select: 1 = level two (static) |
| reg_we | input | 1 | One-cycle register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| restart | input | 1 | Clears the tick count |
| tick | input | 1 | Slow tick, one clock wide per tick |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt request |

## Verification
The bench puts the second unlock step in the last legal cycle of the window and then one cycle later. A window that is off by one either refuses the legal write or lets the late write turn the watchdog off. Timeouts are matched to the exact cycle, including a restart in the middle of a period and a reserved select code. A wrong terminal count, a restart that does not clear the count, or no saturation would shift or lose reset events. The interrupt-then-reset order and the write-one-to-clear flag are checked both ways, so a design that resets on the first timeout, or that clears the flag on a zero write, gives an event or a read-back that does not match.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W   = 8;
  localparam int PRESC_W = 4;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               en;
    logic               chg;
    logic               ie;
    logic               flag;
  } wdt_reg_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_chg,
  input  logic wr_enb,
  output logic open,
  output logic accept
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt;
  logic          arm;

  assign arm    = wr_stb & wr_chg & wr_enb;
  assign open   = (cnt != '0);
  assign accept = wr_stb & open & ~wr_chg;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (arm)             cnt <= CW'(WIN_CYC);
    else if (wr_stb && open)  cnt <= '0;
    else if (open)            cnt <= cnt - 1'b1;
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIN_CYC)); // R5
  AST_STEP_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> open); // R4
  AST_WIN_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1) && !wr_stb) |=> !open); // R6
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int BASE_EXP = 11,
  parameter int TOP_CODE = 9,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int CNT_W = BASE_EXP + TOP_CODE;
  localparam int IDX_W = (TOP_CODE < 1) ? 1 : $clog2(TOP_CODE + 1);

  logic [CNT_W-1:0] term [TOP_CODE+1];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] eff;

  for (genvar g = 0; g <= TOP_CODE; g++) begin : g_term
    assign term[g] = {CNT_W{1'b1}} >> (TOP_CODE - g);
  end

  assign eff    = (sel > SEL_W'(TOP_CODE)) ? IDX_W'(TOP_CODE) : IDX_W'(sel);
  assign expire = run & tick & ~kick & (cnt == term[eff]);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || kick)   cnt <= '0;
    else if (expire)         cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end

  AST_KICK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0)); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0)); // R8
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int TOP_CODE = 9,
  parameter int WIN_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_lvl2,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             restart,
  input  logic             tick,
  output logic             rst_req,
  output logic             irq
);
  wdt_reg_t           w;
  wdt_reg_t           rd;
  logic               en_q, ie_q, flag_q, rst_req_q;
  logic [PRESC_W-1:0] presc_q;
  logic               en_eff, run, win_open, accept, expire;

  assign w      = wdt_reg_t'(reg_wdata);
  assign en_eff = strap_lvl2 | en_q;
  assign run    = en_eff | ie_q;

  wdt_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (reg_we),
    .wr_chg (w.chg),
    .wr_enb (w.en),
    .open   (win_open),
    .accept (accept)
  );

  wdt_timer #(.BASE_EXP(BASE_EXP), .TOP_CODE(TOP_CODE), .SEL_W(PRESC_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tick),
    .kick   (restart),
    .sel    (presc_q),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
      presc_q   <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      if (reg_we) ie_q <= w.ie;
      if (!strap_lvl2) begin
        if (accept)                en_q <= w.en;
        else if (reg_we && w.en)   en_q <= 1'b1;
      end
      if (strap_lvl2 ? accept : reg_we) presc_q <= w.presc;
      if (reg_we && w.flag) flag_q <= 1'b0;
      if (expire) begin
        if (ie_q && !flag_q) flag_q    <= 1'b1;
        else if (en_eff)     rst_req_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd.presc = presc_q;
    rd.en    = en_eff;
    rd.chg   = win_open;
    rd.ie    = ie_q;
    rd.flag  = flag_q;
  end

  assign reg_rdata = rd;
  assign rst_req   = rst_req_q;
  assign irq       = flag_q & ie_q;

  AST_LVL2_EN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    strap_lvl2 |-> reg_rdata[3]); // R3
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_DIS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_lvl2 && en_q && reg_we && !w.en && !win_open) |=> en_q); // R2
  AST_LVL2_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_lvl2 && !accept) |=> $stable(presc_q)); // R7
endmodule

// File: tb/wdt_guarded_tb.sv
module wdt_guarded_tb;
  localparam int BASE = 4;
  localparam int TOPC = 9;
  localparam int WIN  = 4;
  localparam int EV_RST = 0;
  localparam int EV_IRQ = 1;

  typedef struct { int kind; int at; } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_lvl2 = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       restart = 1'b0;
  logic       tick = 1'b0;
  logic       rst_req, irq;

  int  cyc = 0;
  int  nchk = 0;
  int  nfail = 0;
  bit  done = 0;
  bit  irq_d = 0;
  ev_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guarded #(.BASE_EXP(BASE), .TOP_CODE(TOPC), .WIN_CYC(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_lvl2(strap_lvl2), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .restart(restart),
    .tick(tick), .rst_req(rst_req), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic see_event(int kind);
    ev_t e;
    nchk++;
    if (exp_q.size() == 0) begin
      nfail++;
      $display("FAIL R8/R9/R11: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        nfail++;
        $display("FAIL R8/R9/R10/R11: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: pops expected timeout events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) see_event(EV_RST);
      if (irq && !irq_d) see_event(EV_IRQ);
    end
    irq_d = irq;
  end

  task automatic push(int kind, int at);
    ev_t e;
    e.kind = kind;
    e.at   = at;
    exp_q.push_back(e);
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset(logic lvl2);
    check("R8/R11 pending events", exp_q.size(), 0);
    exp_q.delete();
    rst_n = 1'b0;
    tick = 1'b0;
    strap_lvl2 = lvl2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int t;
    int k;
    @(negedge clk);
    // ---------- level one register behaviour ----------
    do_reset(1'b0);
    check("R1 level one reset", reg_rdata, 8'h00);
    wr(8'h08);
    check("R2 set enable", reg_rdata, 8'h08);
    wr(8'h00);
    check("R2 clear ignored", reg_rdata, 8'h08);
    wr(8'h0C);
    check("R4 window open", reg_rdata, 8'h0C);
    idle(WIN - 1);
    wr(8'h00);
    check("R5 last-cycle step two disables", reg_rdata, 8'h00);
    wr(8'h0C);
    idle(WIN);
    check("R6 window closed", reg_rdata, 8'h08);
    wr(8'h00);
    check("R6 late step two ignored", reg_rdata, 8'h08);
    wr(8'h38);
    check("R7 level one select write", reg_rdata, 8'h38);

    // ---------- reset mode and restart ----------
    do_reset(1'b0);
    wr(8'h08);
    t = cyc;
    tick = 1'b1;
    push(EV_RST, t + 16);
    push(EV_RST, t + 32);
    wait_cyc(t + 36);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    k = t + 37;
    push(EV_RST, k + 16); // R10
    wait_cyc(k + 18);
    tick = 1'b0;

    // ---------- timeout lengths ----------
    do_reset(1'b0);
    wr(8'h18);
    t = cyc;
    tick = 1'b1;
    push(EV_RST, t + 32); // R8 code 1
    wait_cyc(t + 34);
    do_reset(1'b0);
    wr(8'hC8);
    t = cyc;
    tick = 1'b1;
    push(EV_RST, t + (1 << (BASE + TOPC))); // R8 reserved code saturates
    wait_cyc(t + (1 << (BASE + TOPC)) + 2);

    // ---------- interrupt then reset, flag clearing ----------
    do_reset(1'b0);
    wr(8'h0A);
    t = cyc;
    tick = 1'b1;
    push(EV_IRQ, t + 16); // R11
    push(EV_RST, t + 32); // R11
    wait_cyc(t + 17);
    check("R11 flag set", reg_rdata, 8'h0B);
    wait_cyc(t + 40);
    wr(8'h0B);
    check("R12 write one clears", reg_rdata, 8'h0A);
    push(EV_IRQ, t + 48);
    wait_cyc(t + 50);
    wr(8'h0A);
    check("R12 write zero keeps", reg_rdata, 8'h0B);
    tick = 1'b0;

    // ---------- interrupt only mode ----------
    do_reset(1'b0);
    wr(8'h02);
    t = cyc;
    tick = 1'b1;
    push(EV_IRQ, t + 16); // R11, no reset at t+32
    wait_cyc(t + 40);
    check("R11 interrupt line", irq, 1);

    // ---------- level two ----------
    do_reset(1'b1);
    check("R1 level two reset", reg_rdata, 8'h08);
    wr(8'h10);
    check("R7 level two unguarded select", reg_rdata, 8'h08);
    wr(8'h0C);
    check("R4 level two window", reg_rdata, 8'h0C);
    wr(8'h10);
    check("R3 R5 level two step two", reg_rdata, 8'h18);
    wr(8'h20);
    check("R7 level two plain write", reg_rdata, 8'h18);
    wr(8'h0C);
    idle(WIN);
    wr(8'h30);
    check("R6 level two late step", reg_rdata, 8'h18);
    t = cyc;
    tick = 1'b1;
    push(EV_RST, t + 32); // R8 at level two
    wait_cyc(t + 34);
    tick = 1'b0;
    check("R8 pending events", exp_q.size(), 0);
    finish_run();
  end
endmodule